// File: doc/BRIEF.md
# Data Bus Line Self-Test Sequencer

This block is a built-in self-test engine for a 64-bit memory data path. When started, it works on one target word and its upper neighbour. It runs a fixed set of twelve stripe patterns, each with a different stripe width, together with their complements. For each pattern it writes the pattern to the target word. It then writes a fixed decoy word to the next address, so that a data line left floating cannot hold the value just driven. Last, it reads the target back once. The single captured value is compared with the pattern. A mismatch produces a report of the address, the expected word and the word actually read.

The block drives a plain memory master port. Writes are taken in the cycle they are requested. A read is answered some cycles later by a read-valid strobe, and the engine keeps at most one read in flight. A mismatch does not stop the run: all twelve patterns are always applied. At the end, a one-cycle done pulse is raised and a fail flag tells whether any pattern mismatched. The flag holds until the next start.

Top module: `databus_bist`

## Requirements
- R1: A synchronous active-high reset, taken at any time, brings the engine to idle on the next edge: busy, done, fail flag, memory request and error strobe all low.
- R2: A start pulse sampled while idle raises busy from the next cycle until the done cycle. A start sampled while busy is ignored and does not disturb the running sequence.
- R3: Patterns are applied in index order 0 to 11. For index k below 6, bit b of the pattern is bit k of the number b, giving AAAA..., CCCC..., F0F0..., FF00..., FFFF0000..., FFFFFFFF00000000. For k of 6 and above, the pattern is the complement of pattern 11-k, giving 00000000FFFFFFFF, 0000FFFF..., 00FF..., 0F0F..., 3333..., 5555....
- R4: Each pattern uses exactly three requests in this order: a write of the pattern to the base word, a write of the decoy 0x0123456789ABCDEF to base+1 (wrapping modulo 2^AW), and a read of the base word. A run therefore makes 36 requests.
- R5: No request is issued while a read awaits its read-valid. A read-valid that arrives while no read is awaited is ignored.
- R6: The value present with the awaited read-valid is captured once and compared. On a mismatch, the error strobe is high for one cycle, in the cycle after the read-valid is sampled, together with the base address, the expected pattern and the captured word.
- R7: A mismatch does not end the run: all twelve patterns are applied, and each mismatching one is reported.
- R8: Done is a one-cycle pulse in the cycle after the last read-valid is sampled, which is the same cycle as that pattern's error report. The fail flag is then high if any pattern mismatched. It holds until the next accepted start, which clears it.
- R9: The write-enable encoding is 1 for a write and 0 for a read. Address and write data are meaningful only while the request is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a run |
| base_addr | input | AW | Target word address, sampled with start |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Some pattern mismatched in the last run |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_rvalid |
| mem_rvalid | input | 1 | Read response strobe |
| err_valid | output | 1 | One-cycle mismatch report strobe |
| err_addr | output | AW | Address of the mismatching word |
| err_expect | output | DW | Pattern that was written |
| err_actual | output | DW | Value that was read back |

## Verification
The error report for the final pattern and the done pulse fall in the same cycle, and the fail flag must already include that final mismatch when done is seen. This is provoked by a memory model that corrupts only the twelfth read-back. It is judged by a per-clock reference that expects the error strobe, the done pulse and the raised fail flag together. A second collision comes from a stray read-valid injected while the decoy is written, just before the real read is issued. The reference expects that strobe to leave no report, while the later real response is still compared.

// File: rtl/databus_bist_pkg.sv
package databus_bist_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WPAT,
    S_WDEC,
    S_RREQ,
    S_RWAIT
  } seq_state_t;

  // Stripe value of data bit `pos` for stripe width 2**sel.
  function automatic logic stripe_bit(input int sel, input int pos);
    return ((pos >> sel) & 1) != 0;
  endfunction

  // True when a captured read-back differs from the written pattern.
  function automatic logic words_differ(input logic [63:0] a, input logic [63:0] b);
    return a != b;
  endfunction

endpackage

// File: rtl/databus_bist_patgen.sv
module databus_bist_patgen
  import databus_bist_pkg::*;
#(
  parameter int DW = 64,
  parameter int IW = 4
) (
  input  logic [IW-1:0] idx,
  output logic [DW-1:0] pat
);
  localparam int LW   = $clog2(DW);
  localparam int NPAT = 2 * LW;

  int   sel;
  logic inv;

  always_comb begin
    if (int'(idx) < LW) begin
      sel = int'(idx);
      inv = 1'b0;
    end else begin
      sel = NPAT - 1 - int'(idx);
      inv = 1'b1;
    end
  end

  for (genvar g = 0; g < DW; g++) begin : g_bit
    assign pat[g] = stripe_bit(sel, g) ^ inv;
  end
endmodule

// File: rtl/databus_bist_seq.sv
module databus_bist_seq
  import databus_bist_pkg::*;
#(
  parameter int AW   = 16,
  parameter int IW   = 4,
  parameter int NPAT = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [AW-1:0]   base_in,
  input  logic            rvalid,
  output seq_state_t      state,
  output logic [IW-1:0]   idx,
  output logic [AW-1:0]   base_q,
  output logic            busy,
  output logic            done,
  output logic            start_acc,
  output logic            cmp_en,
  output logic            last_pat
);
  assign start_acc = start && (state == S_IDLE);
  assign cmp_en    = rvalid && (state == S_RWAIT);
  assign last_pat  = idx == IW'(NPAT - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      idx    <= '0;
      base_q <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          state  <= S_WPAT;
          idx    <= '0;
          base_q <= base_in;
          busy   <= 1'b1;
        end
        S_WPAT: state <= S_WDEC;
        S_WDEC: state <= S_RREQ;
        S_RREQ: state <= S_RWAIT;
        S_RWAIT: if (rvalid) begin
          if (last_pat) begin
            state <= S_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end else begin
            idx   <= idx + 1'b1;
            state <= S_WPAT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/databus_bist_report.sv
module databus_bist_report
  import databus_bist_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          cmp_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] expect_w,
  input  logic [DW-1:0] actual_w,
  output logic          err_valid,
  output logic [AW-1:0] err_addr,
  output logic [DW-1:0] err_expect,
  output logic [DW-1:0] err_actual,
  output logic          fail
);
  logic mism;
  assign mism = cmp_en && words_differ(64'(expect_w), 64'(actual_w));

  always_ff @(posedge clk) begin
    if (rst) begin
      err_valid  <= 1'b0;
      err_addr   <= '0;
      err_expect <= '0;
      err_actual <= '0;
      fail       <= 1'b0;
    end else begin
      err_valid <= mism;
      if (mism) begin
        err_addr   <= addr;
        err_expect <= expect_w;
        err_actual <= actual_w;
      end
      if (clear)     fail <= 1'b0;
      else if (mism) fail <= 1'b1;
    end
  end
endmodule

// File: rtl/databus_bist.sv
module databus_bist
  import databus_bist_pkg::*;
#(
  parameter int          AW    = 16,
  parameter int          DW    = 64,
  parameter logic [63:0] DECOY = 64'h0123_4567_89AB_CDEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_rvalid,
  output logic          err_valid,
  output logic [AW-1:0] err_addr,
  output logic [DW-1:0] err_expect,
  output logic [DW-1:0] err_actual
);
  localparam int LW   = $clog2(DW);
  localparam int NPAT = 2 * LW;
  localparam int IW   = $clog2(NPAT);

  seq_state_t    state;
  logic [IW-1:0] idx;
  logic [AW-1:0] base_q;
  logic [DW-1:0] pat;
  logic          start_acc, cmp_en, last_pat;

  // Named internal events, observed by the bound checker.
  logic rd_wait, decoy_phase;
  assign rd_wait     = state == S_RWAIT;
  assign decoy_phase = state == S_WDEC;

  databus_bist_seq #(.AW(AW), .IW(IW), .NPAT(NPAT)) i_seq (
    .clk(clk), .rst(rst), .start(start), .base_in(base_addr), .rvalid(mem_rvalid),
    .state(state), .idx(idx), .base_q(base_q), .busy(busy), .done(done),
    .start_acc(start_acc), .cmp_en(cmp_en), .last_pat(last_pat)
  );

  databus_bist_patgen #(.DW(DW), .IW(IW)) i_pat (.idx(idx), .pat(pat));

  databus_bist_report #(.AW(AW), .DW(DW)) i_rep (
    .clk(clk), .rst(rst), .clear(start_acc), .cmp_en(cmp_en), .addr(base_q),
    .expect_w(pat), .actual_w(mem_rdata), .err_valid(err_valid), .err_addr(err_addr),
    .err_expect(err_expect), .err_actual(err_actual), .fail(fail)
  );

  assign mem_req   = (state == S_WPAT) || decoy_phase || (state == S_RREQ);
  assign mem_we    = state != S_RREQ;
  assign mem_addr  = decoy_phase ? base_q + 1'b1 : base_q;
  assign mem_wdata = decoy_phase ? DECOY[DW-1:0] : pat;
endmodule

// File: rtl/databus_bist_chk.sv
module databus_bist_chk #(
  parameter int          DW    = 64,
  parameter logic [63:0] DECOY = 64'h0123_4567_89AB_CDEF
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          fail,
  input logic          mem_req,
  input logic          mem_we,
  input logic [DW-1:0] mem_wdata,
  input logic          err_valid,
  input logic          rd_wait,
  input logic          decoy_phase,
  input logic          last_pat
);
  logic rst_q = 1'b0;

  always @(posedge clk) begin
    rst_q <= rst;
    // R1
    if (rst_q === 1'b1) begin
      reset_idle_chk: assert (!busy && !done && !fail && !mem_req && !err_valid);
    end
  end

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_last_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(last_pat) && !busy));

  // R5
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    rd_wait |-> !mem_req);

  // R4
  decoy_word_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && decoy_phase) |-> (mem_we && mem_wdata == DECOY[DW-1:0]));

  // R6
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    err_valid |=> !err_valid);
endmodule

bind databus_bist databus_bist_chk #(.DW(DW), .DECOY(DECOY)) i_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .fail(fail),
  .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata), .err_valid(err_valid),
  .rd_wait(rd_wait), .decoy_phase(decoy_phase), .last_pat(last_pat)
);

// File: tb/test_databus_bist.sv
`timescale 1ns/1ps
module test_databus_bist;
  localparam logic [63:0] DEC = 64'h0123456789abcdef;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] base_addr = '0;
  logic        busy, done, fail, mem_req, mem_we, err_valid;
  logic [15:0] mem_addr, err_addr;
  logic [63:0] mem_wdata, err_expect, err_actual;
  logic [63:0] mem_rdata = '0;
  logic        mem_rvalid = 1'b0;

  always #2.5 clk = ~clk;

  databus_bist i_databus_bist (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr), .busy(busy),
    .done(done), .fail(fail), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .err_valid(err_valid), .err_addr(err_addr), .err_expect(err_expect),
    .err_actual(err_actual)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] ref_pat(input int k);
    case (k)
      0: return 64'haaaaaaaaaaaaaaaa;   1: return 64'hcccccccccccccccc;
      2: return 64'hf0f0f0f0f0f0f0f0;   3: return 64'hff00ff00ff00ff00;
      4: return 64'hffff0000ffff0000;   5: return 64'hffffffff00000000;
      6: return 64'h00000000ffffffff;   7: return 64'h0000ffff0000ffff;
      8: return 64'h00ff00ff00ff00ff;   9: return 64'h0f0f0f0f0f0f0f0f;
      10: return 64'h3333333333333333;  default: return 64'h5555555555555555;
    endcase
  endfunction

  // ---------------- memory model configuration ----------------
  int          cfg_lat = 1;
  int          cfg_mode = 0;    // 0 clean, 1 flip one read, 2 bus echoes last write
  int          cfg_flip_k = 0;
  logic [63:0] cfg_mask = '0;
  bit          cfg_stray = 1'b0;

  typedef struct { bit we; logic [15:0] a; logic [63:0] d; } tx_t;
  tx_t txq[$];

  logic [63:0] mem_m [int];
  logic [63:0] last_wr = '0, hold = '0;
  int          cnt = 0, rd_idx = 0, ans_cnt = 0;
  bit          stray_now = 1'b0, pending = 1'b0;
  logic [15:0] exp_base = '0;

  // ---------------- reference state ----------------
  bit          exp_busy = 1'b0, exp_done = 1'b0, exp_err = 1'b0, exp_fail = 1'b0;
  logic [15:0] exp_eaddr = '0;
  logic [63:0] exp_eexp = '0, exp_eact = '0;
  logic        mism_v;

  always @(posedge clk) begin
    if (rst) begin
      mem_rvalid <= 1'b0; cnt <= 0; stray_now <= 1'b0; pending <= 1'b0;
      exp_busy <= 1'b0; exp_done <= 1'b0; exp_err <= 1'b0; exp_fail <= 1'b0;
      txq.delete();
    end else begin
      // reference: consume a real response (R6, R7, R8)
      exp_done <= 1'b0;
      exp_err  <= 1'b0;
      if (mem_rvalid && !stray_now && exp_busy) begin
        mism_v = mem_rdata != ref_pat(ans_cnt);
        exp_err   <= mism_v;
        exp_eaddr <= exp_base;
        exp_eexp  <= ref_pat(ans_cnt);
        exp_eact  <= mem_rdata;
        if (mism_v) exp_fail <= 1'b1;
        pending <= 1'b0;
        ans_cnt <= ans_cnt + 1;
        if (ans_cnt == 11) begin
          exp_busy <= 1'b0;
          exp_done <= 1'b1;
        end
      end
      // reference: accept start only when idle (R2)
      if (start && !exp_busy) begin
        exp_busy <= 1'b1;
        exp_fail <= 1'b0;
        ans_cnt  <= 0;
        rd_idx   <= 0;
        exp_base <= base_addr;
        for (int k = 0; k < 12; k++) begin
          txq.push_back('{1'b1, base_addr, ref_pat(k)});
          txq.push_back('{1'b1, base_addr + 16'd1, DEC});
          txq.push_back('{1'b0, base_addr, 64'h0});
        end
      end
      // memory model
      mem_rvalid <= 1'b0;
      stray_now  <= 1'b0;
      if (cnt == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= hold;
      end
      if (cnt > 0) cnt <= cnt - 1;
      if (mem_req) begin
        if (mem_we) begin
          mem_m[int'(mem_addr)] = mem_wdata;
          last_wr = mem_wdata;
          if (cfg_stray && mem_addr == exp_base + 16'd1) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= 64'hdeadbeefdeadbeef;
            stray_now  <= 1'b1;
          end
        end else begin
          if (cfg_mode == 2)
            hold <= last_wr;
          else if (cfg_mode == 1 && rd_idx == cfg_flip_k)
            hold <= mem_m[int'(mem_addr)] ^ cfg_mask;
          else
            hold <= mem_m[int'(mem_addr)];
          cnt     <= cfg_lat;
          pending <= 1'b1;
          rd_idx  <= rd_idx + 1;
        end
      end
    end
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (!rst) begin
      chk(busy == exp_busy, "R2 busy", 64'(busy), 64'(exp_busy));
      chk(done == exp_done, "R8 done", 64'(done), 64'(exp_done));
      chk(fail == exp_fail, "R8 fail flag", 64'(fail), 64'(exp_fail));
      chk(err_valid == exp_err, "R6 err strobe", 64'(err_valid), 64'(exp_err));
      if (err_valid && exp_err) begin
        chk(err_addr == exp_eaddr, "R6 err addr", 64'(err_addr), 64'(exp_eaddr));
        chk(err_expect == exp_eexp, "R6 err expected", err_expect, exp_eexp);
        chk(err_actual == exp_eact, "R6 err actual", err_actual, exp_eact);
      end
      if (mem_req) begin
        chk(!pending, "R5 request while read pending", 64'(pending), 64'd0);
        if (txq.size() == 0) begin
          chk(1'b0, "R4 unexpected request", 64'(mem_addr), 64'd0);
        end else begin
          tx_t t;
          t = txq.pop_front();
          chk(mem_we == t.we, "R9 write enable", 64'(mem_we), 64'(t.we));
          chk(mem_addr == t.a, "R4 address", 64'(mem_addr), 64'(t.a));
          if (t.we) chk(mem_wdata == t.d, "R3 write data", mem_wdata, t.d);
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  int errs_seen;
  bit done_with_err;

  task automatic run(input logic [15:0] b, input int lat, input int mode, input int fk,
                     input logic [63:0] mask, input bit stray, input bit restart_mid);
    cfg_lat = lat; cfg_mode = mode; cfg_flip_k = fk; cfg_mask = mask; cfg_stray = stray;
    errs_seen = 0; done_with_err = 1'b0;
    @(negedge clk);
    base_addr = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (restart_mid && i == 20) begin
        start = 1'b1; base_addr = b ^ 16'h00f0;
      end else begin
        start = 1'b0;
      end
      if (err_valid) errs_seen++;
      if (done) begin
        done_with_err = err_valid;
        break;
      end
      @(negedge clk);
    end
    chk(done, "R8 run finished", 64'(done), 64'd1);
    chk(txq.size() == 0, "R4 all 36 requests issued", 64'(txq.size()), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !fail && !mem_req && !err_valid, "R1 reset state",
        {59'd0, busy, done, fail, mem_req, err_valid}, 64'd0);
    rst = 1'b0;

    // clean run, latency 1
    run(16'h0100, 1, 0, 0, '0, 1'b0, 1'b0);
    chk(!fail, "R8 clean run passes", 64'(fail), 64'd0);
    chk(errs_seen == 0, "R6 no reports on clean run", 64'(errs_seen), 64'd0);

    // one corrupted line in pattern 3, latency 3
    run(16'h2468, 3, 1, 3, 64'h0000_0000_0001_0000, 1'b0, 1'b0);
    chk(fail, "R8 fail raised", 64'(fail), 64'd1);
    chk(errs_seen == 1, "R7 single report, run continued", 64'(errs_seen), 64'd1);
    repeat (6) @(negedge clk);
    chk(fail && !busy, "R8 fail held while idle", 64'(fail), 64'd1);

    // last pattern corrupted: report and done coincide, and new start clears flag
    run(16'h0040, 2, 1, 11, 64'h8000_0000_0000_0000, 1'b0, 1'b0);
    chk(done_with_err, "R8 done with last report", 64'(done_with_err), 64'd1);
    chk(fail, "R8 fail includes last pattern", 64'(fail), 64'd1);

    // floating bus echoes last write: every read shows decoy
    run(16'h0333, 1, 2, 0, '0, 1'b0, 1'b0);
    chk(errs_seen == 12, "R7 all twelve patterns reported", 64'(errs_seen), 64'd12);

    // top word: decoy wraps to 0, stray read-valid must be ignored
    run(16'hffff, 2, 0, 0, '0, 1'b1, 1'b0);
    chk(!fail, "R5 stray strobe ignored", 64'(fail), 64'd0);
    chk(mem_m[0] == DEC, "R4 decoy wrapped to word 0", mem_m[0], DEC);

    // start while busy must be ignored
    run(16'h0500, 1, 0, 0, '0, 1'b0, 1'b1);
    chk(!fail, "R2 restart ignored", 64'(fail), 64'd0);

    // reset in the middle of a failing run
    cfg_mode = 2;
    @(negedge clk); base_addr = 16'h0700; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (25) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !fail && !mem_req && !err_valid, "R1 mid-run reset",
        {59'd0, busy, done, fail, mem_req, err_valid}, 64'd0);
    rst = 1'b0;
    run(16'h0010, 4, 0, 0, '0, 1'b0, 1'b0);
    chk(!fail, "R1 clean run after reset", 64'(fail), 64'd0);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule